// File: doc/BRIEF.md
# Single-Accumulator Processor with Interrupt Cycle

This block is a small 16-bit processor built around one accumulator. It repeats a fixed instruction cycle against a 4096-word by 16-bit memory that it owns. Each instruction is fetched into an instruction register from the address held in the program counter. The program counter then advances, and the opcode is decoded. An operand is read or written through a memory address register and a memory buffer register. After each completed instruction the processor checks for an interrupt.

Arithmetic uses sign-magnitude numbers. When an interrupt request is seen while interrupts are enabled, the program counter and accumulator are saved and execution moves to a fixed handler address. A return opcode restores the saved state. Any opcode the processor does not recognise stops it for good, until the next reset.

While reset is held low, a test load port writes words straight into the memory. Releasing reset starts execution at address 0.

Top module: `acc_machine`

## Requirements
- R1: While reset is asserted, the processor shows pc = 0, acc = 0, int_en = 1, ovf = 0, halted = 0 and retire = 0.
- R2: While rst_n is low, a word on ld_data is written at ld_addr on each clock edge where ld_we is high. Programs and data placed this way are what the processor runs on after reset is released.
- R3: An instruction word carries its opcode in bits [15:12] and a 12-bit memory address in bits [11:0]. It is fetched from the address in pc, and pc then increases by one.
- R4: Opcode 4'b0001 copies the addressed memory word into acc.
- R5: Opcode 4'b0010 writes acc to the addressed memory word and leaves acc unchanged.
- R6: Opcode 4'b0101 adds the addressed word to acc in sign-magnitude form, with bit 15 as the sign (1 = negative) and bits [14:0] as the magnitude. Operands with equal signs have their magnitudes added and keep that sign. Operands with different signs give the difference of the magnitudes, carrying the sign of the operand with the larger magnitude.
- R7: An add whose result magnitude is zero always gives 16'h0000, never a negative zero.
- R8: An add whose magnitude sum overflows 15 bits keeps the low 15 bits of the sum and sets ovf. Once set, ovf stays set until reset.
- R9: At the end of each instruction, if irq is high and int_en is 1, pc and acc are saved, pc becomes 12'hF00 and int_en clears.
- R10: While int_en is 0, a high irq has no effect, and the next instruction follows in sequence.
- R11: Opcode 4'b1111 restores the saved pc and acc and sets int_en again.
- R12: Any other opcode raises halted, which then stays high. pc is left one past the halting instruction, and no further instruction completes.
- R13: retire is high for exactly one cycle after each completed instruction, at the point where interrupts are checked. During that cycle, pc already holds the address of the next instruction in sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also enables the load port |
| ld_we | input | 1 | Load port write strobe, honoured only during reset |
| ld_addr | input | 12 | Load port word address |
| ld_data | input | 16 | Load port write data |
| irq | input | 1 | Interrupt request level |
| acc | output | 16 | Accumulator |
| pc | output | 12 | Program counter |
| retire | output | 1 | One-cycle pulse per completed instruction |
| int_en | output | 1 | Interrupt enable flag |
| ovf | output | 1 | Sticky magnitude overflow flag |
| halted | output | 1 | High once an unknown opcode has been decoded |

## Verification
On every cycle, the embedded properties check the following rules. The program counter advances by one after each fetch. A taken interrupt lands on the handler with the enable cleared, and a masked request leaves the program counter alone. Overflow and halt are sticky, retire never lasts two cycles, and no add yields a negative zero. Only the bench scenarios can show the arithmetic values themselves, across all mixes of signs and magnitudes. The same holds for a store becoming visible through a later load and for the saved context coming back intact on return. The halt point, and the exact instruction after which an interrupt is taken, also rest on those scenarios.

// File: rtl/acc_pkg.sv
// Shared opcodes and control states for the accumulator machine.
// Assumes a 4-bit opcode field in the top nibble of each instruction word.
package acc_pkg;
    localparam logic [3:0] OP_LOAD  = 4'b0001;
    localparam logic [3:0] OP_STORE = 4'b0010;
    localparam logic [3:0] OP_ADD   = 4'b0101;
    localparam logic [3:0] OP_RET   = 4'b1111;

    typedef enum logic [3:0] {
        ST_FADR,   // copy pc into address register
        ST_FWAIT,  // memory read of instruction in flight
        ST_DEC,    // capture instruction, advance pc, decode
        ST_OWAIT,  // memory read of operand in flight
        ST_OCAP,   // operand into buffer register
        ST_EXEC,   // load or add into acc
        ST_SBUF,   // acc into buffer register
        ST_SWR,    // buffer register written to memory
        ST_RET,    // restore context
        ST_ICHK,   // interrupt check, instruction complete
        ST_HALT    // stopped on unknown opcode
    } state_t;
endpackage

// File: rtl/acc_mem.sv
// Single-port word memory with one cycle of read latency.
// Assumes: the read data register reflects the word at addr one edge later;
// a write and a read of the same word in one cycle return the old word.
module acc_mem #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    // Purpose: synchronous write and registered read.
    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
        rdata <= words[addr];
    end
endmodule

// File: rtl/acc_smadd.sv
// Combinational sign-magnitude adder.
// Assumes the top bit is the sign (1 = negative) and the rest is magnitude.
// Overflow of the magnitude drops the carry and flags it; zero is positive.
module acc_smadd #(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry
);
    localparam int MW = W - 1;

    logic [MW-1:0] ma, mb, mres;
    logic [MW:0]   wide;
    logic          sres;

    assign ma = a[MW-1:0];
    assign mb = b[MW-1:0];

    // Purpose: pick add or subtract of magnitudes and the result sign.
    always_comb begin
        wide  = '0;
        carry = 1'b0;
        if (a[W-1] == b[W-1]) begin
            wide  = {1'b0, ma} + {1'b0, mb};
            mres  = wide[MW-1:0];
            carry = wide[MW];
            sres  = a[W-1];
        end else if (ma >= mb) begin
            mres = ma - mb;
            sres = a[W-1];
        end else begin
            mres = mb - ma;
            sres = b[W-1];
        end
        if (mres == '0) begin
            sres = 1'b0;
        end
        sum = {sres, mres};
    end

    // R7: the adder never emits a negative zero
    always_comb begin
        a_r7_no_neg_zero: assert (!(sum[W-1] && sum[MW-1:0] == '0));
    end
endmodule

// File: rtl/acc_machine.sv
// Single-accumulator processor: fetch, decode, execute and interrupt check.
// Assumes: synchronous active-low reset; the load port owns the memory
// while reset is low; the handler entry address is a parameter.
module acc_machine
    import acc_pkg::*;
#(
    parameter int              AW           = 12,
    parameter int              DW           = 16,
    parameter int              OPW          = 4,
    parameter logic [AW-1:0]   HANDLER_ADDR = 12'hF00
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_we,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic          irq,
    output logic [DW-1:0] acc,
    output logic [AW-1:0] pc,
    output logic          retire,
    output logic          int_en,
    output logic          ovf,
    output logic          halted
);
    localparam int OP_LSB = DW - OPW;

    state_t        state;
    logic [DW-1:0] ir, mbr, rdata, sum, saved_acc;
    logic [AW-1:0] mar, saved_pc;
    logic          carry;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [OPW-1:0] op_now;

    // R2: the load port drives the memory while reset is held
    assign mem_we    = rst_n ? (state == ST_SWR) : ld_we;
    assign mem_addr  = rst_n ? mar : ld_addr;
    assign mem_wdata = rst_n ? mbr : ld_data;
    assign op_now    = rdata[DW-1:OP_LSB];

    acc_mem #(.AW(AW), .DW(DW)) i_mem (
        .clk   (clk),
        .we    (mem_we),
        .addr  (mem_addr),
        .wdata (mem_wdata),
        .rdata (rdata)
    );

    acc_smadd #(.W(DW)) i_add (
        .a     (acc),
        .b     (mbr),
        .sum   (sum),
        .carry (carry)
    );

    assign retire = (state == ST_ICHK);
    assign halted = (state == ST_HALT);

    // Purpose: control sequence and all datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_FADR;
            pc        <= '0;
            acc       <= '0;
            ir        <= '0;
            mar       <= '0;
            mbr       <= '0;
            saved_pc  <= '0;
            saved_acc <= '0;
            int_en    <= 1'b1;
            ovf       <= 1'b0;
        end else begin
            case (state)
                ST_FADR: begin
                    mar   <= pc;
                    state <= ST_FWAIT;
                end
                ST_FWAIT: state <= ST_DEC;
                ST_DEC: begin
                    // R3: capture instruction and step pc
                    ir  <= rdata;
                    pc  <= pc + 1'b1;
                    mar <= rdata[AW-1:0];
                    case (op_now)
                        OP_LOAD, OP_ADD: state <= ST_OWAIT;
                        OP_STORE:        state <= ST_SBUF;
                        OP_RET:          state <= ST_RET;
                        default:         state <= ST_HALT;  // R12
                    endcase
                end
                ST_OWAIT: state <= ST_OCAP;
                ST_OCAP: begin
                    mbr   <= rdata;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (ir[DW-1:OP_LSB] == OP_LOAD) begin
                        acc <= mbr;                      // R4
                    end else begin
                        acc <= sum;                      // R6
                        if (carry) ovf <= 1'b1;          // R8
                    end
                    state <= ST_ICHK;
                end
                ST_SBUF: begin
                    mbr   <= acc;                        // R5
                    state <= ST_SWR;
                end
                ST_SWR: state <= ST_ICHK;
                ST_RET: begin
                    pc     <= saved_pc;                  // R11
                    acc    <= saved_acc;
                    int_en <= 1'b1;
                    state  <= ST_ICHK;
                end
                ST_ICHK: begin
                    if (irq && int_en) begin             // R9
                        saved_pc  <= pc;
                        saved_acc <= acc;
                        pc        <= HANDLER_ADDR;
                        int_en    <= 1'b0;
                    end
                    state <= ST_FADR;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    // R3: pc steps by one after every decode
    a_r3_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DEC) |=> (pc == $past(pc) + 1'b1));

    // R8: overflow flag is sticky
    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> ovf);

    // R9: a taken interrupt lands on the handler with interrupts masked
    a_r9_enter_handler: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && irq && int_en) |=> (pc == HANDLER_ADDR && !int_en));

    // R10: a masked request leaves the program counter in sequence
    a_r10_masked_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (retire && !int_en) |=> (pc == $past(pc)));

    // R12: halt holds and nothing completes afterwards
    a_r12_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !retire));

    // R13: retire is a single-cycle pulse
    a_r13_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);
endmodule

// File: tb/test_acc_machine.sv
// Scoreboard bench: a driver task queues expected retire results, a monitor
// pops and compares them each time the processor completes an instruction.
module test_acc_machine;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic        clk = 1'b0;
    logic        rst_n, ld_we, irq;
    logic [11:0] ld_addr;
    logic [15:0] ld_data;
    logic [15:0] acc;
    logic [11:0] pc;
    logic        retire, int_en, ovf, halted;

    int n_chk  = 0;
    int n_fail = 0;
    int n_ret  = 0;
    bit done   = 1'b0;

    typedef struct {
        string       req;
        logic [15:0] acc;
        logic [11:0] pc;
        logic        ovf;
        logic        ie;
    } exp_t;

    exp_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_machine i_acc_machine (
        .clk(clk), .rst_n(rst_n), .ld_we(ld_we), .ld_addr(ld_addr),
        .ld_data(ld_data), .irq(irq), .acc(acc), .pc(pc), .retire(retire),
        .int_en(int_en), .ovf(ovf), .halted(halted)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic push_exp(string req, logic [15:0] a, logic [11:0] p, logic o, logic ie);
        exp_t e;
        e.req = req; e.acc = a; e.pc = p; e.ovf = o; e.ie = ie;
        exp_q.push_back(e);
    endtask

    task automatic load_word(logic [11:0] a, logic [15:0] d);
        ld_we = 1'b1; ld_addr = a; ld_data = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Monitor: compare each completed instruction against the queue (R13)
    always @(negedge clk) begin
        if (rst_n === 1'b1 && retire === 1'b1) begin
            n_ret++;
            if (exp_q.size() == 0) begin
                check("R13", "unexpected retire", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.req, "acc", {16'h0, acc}, {16'h0, e.acc});
                check(e.req, "pc", {20'h0, pc}, {20'h0, e.pc});
                check(e.req, "ovf", {31'h0, ovf}, {31'h0, e.ovf});
                check(e.req, "int_en", {31'h0, int_en}, {31'h0, e.ie});
            end
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        check("R12", "watchdog expired", 32'd1, 32'd0);
        finish_up();
    end

    initial begin
        rst_n = 1'b0; ld_we = 1'b0; irq = 1'b0; ld_addr = '0; ld_data = '0;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", "pc", {20'h0, pc}, 32'h0);
        check("R1", "acc", {16'h0, acc}, 32'h0);
        check("R1", "int_en", {31'h0, int_en}, 32'h1);
        check("R1", "ovf", {31'h0, ovf}, 32'h0);
        check("R1", "halted", {31'h0, halted}, 32'h0);
        check("R1", "retire", {31'h0, retire}, 32'h0);

        // R2: program and data written through the load port during reset
        // opcodes: 1=load 2=store 5=add F=return; top nibble is the opcode
        load_word(12'h000, 16'h1100);
        load_word(12'h001, 16'h5101);
        load_word(12'h002, 16'h5102);
        load_word(12'h003, 16'h5103);
        load_word(12'h004, 16'h5101);
        load_word(12'h005, 16'h5101);
        load_word(12'h006, 16'h2110);
        load_word(12'h007, 16'h1103);
        load_word(12'h008, 16'h5102);
        load_word(12'h009, 16'h1110);
        load_word(12'h00A, 16'h1104);
        load_word(12'h00B, 16'h5105);
        load_word(12'h00C, 16'h1100);
        load_word(12'h00D, 16'h5100);
        load_word(12'h00E, 16'h1101);
        load_word(12'h00F, 16'h3000);
        load_word(12'h100, 16'h0005);   // +5
        load_word(12'h101, 16'h8003);   // -3
        load_word(12'h102, 16'h8007);   // -7
        load_word(12'h103, 16'h0007);   // +7
        load_word(12'h104, 16'h7FFF);   // largest positive
        load_word(12'h105, 16'h0002);   // +2
        load_word(12'h110, 16'h0000);
        load_word(12'hF00, 16'h1103);   // handler
        load_word(12'hF01, 16'h5103);
        load_word(12'hF02, 16'hF000);

        // Driver: expected results in retire order
        push_exp("R4 R3",  16'h0005, 12'h001, 1'b0, 1'b1);
        push_exp("R6",     16'h0002, 12'h002, 1'b0, 1'b1);
        push_exp("R6",     16'h8005, 12'h003, 1'b0, 1'b1);
        push_exp("R6",     16'h0002, 12'h004, 1'b0, 1'b1);
        push_exp("R6",     16'h8001, 12'h005, 1'b0, 1'b1);
        push_exp("R6",     16'h8004, 12'h006, 1'b0, 1'b1);
        push_exp("R5",     16'h8004, 12'h007, 1'b0, 1'b1);
        push_exp("R4",     16'h0007, 12'h008, 1'b0, 1'b1);
        push_exp("R7",     16'h0000, 12'h009, 1'b0, 1'b1);
        push_exp("R5",     16'h8004, 12'h00A, 1'b0, 1'b1);
        push_exp("R4",     16'h7FFF, 12'h00B, 1'b0, 1'b1);
        push_exp("R8",     16'h0001, 12'h00C, 1'b1, 1'b1);
        push_exp("R8",     16'h0005, 12'h00D, 1'b1, 1'b1);
        push_exp("R9",     16'h0007, 12'hF01, 1'b1, 1'b0);
        push_exp("R10",    16'h000E, 12'hF02, 1'b1, 1'b0);
        push_exp("R11",    16'h0005, 12'h00D, 1'b1, 1'b1);
        push_exp("R6",     16'h000A, 12'h00E, 1'b1, 1'b1);
        push_exp("R4",     16'h8003, 12'h00F, 1'b1, 1'b1);

        rst_n = 1'b1;

        // R9: request after the 13th instruction; R10: held high in handler
        wait (n_ret == 13);
        irq = 1'b1;
        wait (n_ret == 15);
        irq = 1'b0;

        wait (halted === 1'b1);
        repeat (4) @(negedge clk);
        // R12: halt point and stickiness
        check("R12", "halted", {31'h0, halted}, 32'h1);
        check("R12", "pc", {20'h0, pc}, 32'h010);
        check("R12", "acc", {16'h0, acc}, 32'h8003);
        check("R13", "retire count", n_ret, 32'd18);
        check("R13", "queue empty", exp_q.size(), 32'd0);
        finish_up();
    end
endmodule